// File: doc/BRIEF.md
# Page Write Buffer with Commit Sequencer

This block sits between a serial memory's protocol engine and its storage array. While a write transfer is open, it collects the received data bytes into a small page latch. Each slot of the latch carries its own loaded flag. The slot address comes from a word pointer: it is loaded from the transferred word address, and only its low bits advance after each byte. A run that passes the end of the page therefore wraps back to the start of that same page, and the newest bytes overwrite the oldest.

When the transfer is closed by a STOP and at least one byte was received, the block starts an internal program cycle of a fixed, parameterised number of clocks. Busy stays high for that whole cycle. During its first cycles the block walks the page slots in ascending order and issues one array write per clock, only for slots that hold a byte. A sampled write-control level can suppress these writes for the upper half of the array. While busy is high the block ignores every input strobe, so the protocol engine can use busy to refuse acknowledges. The pointer output serves as the shared address counter for a later current-address access.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, busy is low, no array write is issued and next_addr is 0.
- R2: A byte accepted while idle increments only the low four bits of next_addr (the slot index), wrapping from 15 to 0, while the upper bits (the page) stay fixed. Loading a word address sets next_addr to it.
- R3: When more than 16 bytes arrive in one transfer, each later byte replaces the slot of the byte 16 positions earlier, so the 17th lands where the first did.
- R4: A program cycle starts only on a STOP that follows at least one accepted byte since the last START. A STOP with no byte leaves busy low and issues no write.
- R5: Busy rises on the clock after the starting STOP and stays high for exactly PROG_CYCLES clocks.
- R6: In busy cycle i, for i from 0 to 15, the block writes slot i of the current page at address {page, i} with that slot's latest byte. It writes only if the slot was loaded in this transfer, and it issues at most one write per clock.
- R7: The write-control level is sampled at START. When it is high and the page has address bit 10 set (0x400 to 0x7FF), no array write is issued but busy still runs its full length. Lower pages, or a low level, write normally.
- R8: While busy is high, START, word-address, byte and STOP strobes are ignored: next_addr does not change, and no second program cycle follows.
- R9: START clears all slot flags, so bytes latched in an earlier transfer are not written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | One-cycle strobe: START of a write transfer |
| wp_pin | input | 1 | Write-control level, sampled at xfer_start |
| addr_load | input | 1 | One-cycle strobe: word address on addr_in is valid |
| addr_in | input | ADDR_W | Full word address (page and slot) |
| byte_vld | input | 1 | One-cycle strobe: data byte on byte_in is valid |
| byte_in | input | DATA_W | Received data byte |
| stop_strb | input | 1 | One-cycle strobe: STOP ending the transfer |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| next_addr | output | ADDR_W | Word pointer (shared address counter) |

## Verification
The assertions rely on the protocol engine raising at most one of the START, word-address, byte and STOP strobes in a cycle. They also rely on the write-control level staying constant between START and STOP. The stimulus raises each strobe alone for a single clock, with an idle clock after it, and changes the write-control level only before a START. The one deliberate exception is a burst of strobes during busy, which the block must ignore.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   // Which part of the array the write-control level guards
   typedef enum logic [0:0] {
      GUARD_UPPER_HALF = 1'b0,
      GUARD_WHOLE      = 1'b1
   } guard_mode_e;
endpackage

// File: rtl/pgbuf_slots.sv
module pgbuf_slots #(
   parameter int DATA_W = 8,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [SLOT_W-1:0] load_slot,
   input  logic [DATA_W-1:0] load_data,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              any_valid
);
   localparam int DEPTH = 1 << SLOT_W;

   logic [DEPTH-1:0]  mask;
   logic [DATA_W-1:0] byte_arr [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         logic              v_q;
         logic [DATA_W-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
            end else if (clr) begin
               v_q <= 1'b0;
            end else if (load && (load_slot == SLOT_W'(s))) begin
               v_q <= 1'b1;
               d_q <= load_data;
            end
         end
         assign mask[s]     = v_q;
         assign byte_arr[s] = d_q;
      end
   endgenerate

   assign rd_valid  = mask[rd_slot];
   assign rd_data   = byte_arr[rd_slot];
   assign any_valid = |mask;
endmodule

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr #(
   parameter int ADDR_W = 11,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   localparam int PAGE_W = ADDR_W - SLOT_W;

   logic [PAGE_W-1:0] page_q;
   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         slot_q <= '0;
      end else if (load) begin
         page_q <= load_addr[ADDR_W-1:SLOT_W];
         slot_q <= load_addr[SLOT_W-1:0];
      end else if (step) begin
         slot_q <= slot_q + 1'b1;   // page bits never carry
      end
   end

   assign ptr = {page_q, slot_q};
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
   parameter int CYCLES = 64,
   parameter int CNT_W  = $clog2(CYCLES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output logic             busy,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         count <= '0;
      end else if (!busy) begin
         if (go) begin
            busy  <= 1'b1;
            count <= '0;
         end
      end else if (count == LAST) begin
         busy <= 1'b0;
      end else begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
   import pgbuf_pkg::*;
#(
   parameter int          ADDR_W      = 11,
   parameter int          DATA_W      = 8,
   parameter int          SLOT_W      = 4,
   parameter int          PROG_CYCLES = 64,
   parameter guard_mode_e GUARD       = GUARD_UPPER_HALF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic              wp_pin,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              stop_strb,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_data,
   output logic [ADDR_W-1:0] next_addr
);
   localparam int DEPTH  = 1 << SLOT_W;
   localparam int PAGE_W = ADDR_W - SLOT_W;
   localparam int CNT_W  = $clog2(PROG_CYCLES);

   generate
      if (PROG_CYCLES <= DEPTH) begin : g_bad_cycles
         $error("PROG_CYCLES must exceed the page depth");
      end
      if (SLOT_W < 1 || SLOT_W >= ADDR_W) begin : g_bad_slot
         $error("SLOT_W must lie between 1 and ADDR_W-1");
      end
   endgenerate

   logic              accept;
   logic              wp_q;
   logic              rd_valid;
   logic              any_valid;
   logic [DATA_W-1:0] rd_data;
   logic [CNT_W-1:0]  count;
   logic              scanning;
   logic              blocked;
   logic [PAGE_W-1:0] page;
   logic [SLOT_W-1:0] scan_slot;

   assign accept = !busy;

   // write-control level latched once per transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   wp_q <= 1'b0;
      else if (xfer_start && accept) wp_q <= wp_pin;
   end

   pgbuf_ptr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (addr_load && accept),
      .load_addr (addr_in),
      .step      (byte_vld && accept),
      .ptr       (next_addr)
   );

   assign page      = next_addr[ADDR_W-1:SLOT_W];
   assign scan_slot = count[SLOT_W-1:0];

   pgbuf_slots #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (xfer_start && accept),
      .load      (byte_vld && accept),
      .load_slot (next_addr[SLOT_W-1:0]),
      .load_data (byte_in),
      .rd_slot   (scan_slot),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .any_valid (any_valid)
   );

   pgbuf_timer #(.CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (stop_strb && accept && any_valid),
      .busy  (busy),
      .count (count)
   );

   generate
      if (GUARD == GUARD_UPPER_HALF) begin : g_guard_upper
         assign blocked = wp_q && page[PAGE_W-1];
      end else begin : g_guard_whole
         assign blocked = wp_q;
      end
   endgenerate

   assign scanning = busy && (count < CNT_W'(DEPTH));
   assign arr_we   = scanning && rd_valid && !blocked;
   assign arr_addr = {page, scan_slot};
   assign arr_data = rd_data;
endmodule

// File: rtl/pgbuf_commit_chk.sv
module pgbuf_commit_chk #(
   parameter int ADDR_W      = 11,
   parameter int SLOT_W      = 4,
   parameter int PROG_CYCLES = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_strb,
   input logic              byte_vld,
   input logic              addr_load,
   input logic              busy,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr,
   input logic [ADDR_W-1:0] next_addr,
   input logic              wp_q
);
   int run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      else           run_len <= 0;
   end

   // R5: busy run length is exactly the program time
   a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == PROG_CYCLES));

   // R4: a program cycle only follows a STOP
   a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_strb));

   // R6: writes happen only inside the program cycle and on the pointer page
   a_r6_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy && (arr_addr[ADDR_W-1:SLOT_W] == next_addr[ADDR_W-1:SLOT_W]));

   // R7: guarded upper half is never written
   a_r7_guard_upper: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !(wp_q && arr_addr[ADDR_W-1]));

   // R2: a byte keeps the page and advances the slot
   a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !addr_load && !busy) |=>
         (next_addr[ADDR_W-1:SLOT_W] == $past(next_addr[ADDR_W-1:SLOT_W])));

   a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !addr_load && !busy) |=>
         (next_addr[SLOT_W-1:0] == SLOT_W'($past(next_addr[SLOT_W-1:0]) + 1'b1)));

   // R8: pointer frozen while busy
   a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(next_addr));
endmodule

bind pgbuf_commit pgbuf_commit_chk #(
   .ADDR_W      (ADDR_W),
   .SLOT_W      (SLOT_W),
   .PROG_CYCLES (PROG_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stop_strb (stop_strb),
   .byte_vld  (byte_vld),
   .addr_load (addr_load),
   .busy      (busy),
   .arr_we    (arr_we),
   .arr_addr  (arr_addr),
   .next_addr (next_addr),
   .wp_q      (wp_q)
);

// File: tb/pgbuf_commit_tb.sv
module pgbuf_commit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 11;
   localparam int DW   = 8;
   localparam int PROG = 64;
   localparam int MEMN = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xfer_start = 1'b0, wp_pin = 1'b0, addr_load = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          byte_vld = 1'b0;
   logic [DW-1:0] byte_in = '0;
   logic          stop_strb = 1'b0;
   logic          busy, arr_we;
   logic [AW-1:0] arr_addr, next_addr;
   logic [DW-1:0] arr_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgbuf_commit #(.ADDR_W(AW), .DATA_W(DW), .SLOT_W(4), .PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .wp_pin(wp_pin),
      .addr_load(addr_load), .addr_in(addr_in), .byte_vld(byte_vld),
      .byte_in(byte_in), .stop_strb(stop_strb), .busy(busy), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_data(arr_data), .next_addr(next_addr)
   );

   int  n_cmp = 0, n_bad = 0;
   bit  done = 1'b0;
   int  tb_mem [MEMN];
   int  busy_cnt = 0, wr_cnt = 0;

   // behavioural reference state
   bit  m_busy = 0, m_wp = 0;
   int  m_cnt = 0, m_ptr = 0;
   bit  m_mask [16];
   int  m_dat  [16];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit any_mask();
      for (int i = 0; i < 16; i++) if (m_mask[i]) return 1'b1;
      return 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_ptr = 0; m_wp = 0;
         for (int i = 0; i < 16; i++) m_mask[i] = 0;
      end else if (m_busy) begin
         if (m_cnt == PROG - 1) m_busy = 0;
         else m_cnt++;
      end else begin
         if (xfer_start) begin
            m_wp = wp_pin;
            for (int i = 0; i < 16; i++) m_mask[i] = 0;
         end
         if (addr_load) m_ptr = int'(addr_in);
         if (byte_vld) begin
            int s;
            s = m_ptr % 16;
            m_mask[s] = 1;
            m_dat[s]  = int'(byte_in);
            m_ptr = (m_ptr / 16) * 16 + (s + 1) % 16;
         end
         if (stop_strb && any_mask()) begin
            m_busy = 1; m_cnt = 0;
         end
      end
   end

   // per-cycle comparison, a quarter period after the rising edge
   always begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n && !done) begin
         bit e_we;
         int e_addr;
         e_addr = (m_ptr / 16) * 16 + m_cnt;
         e_we = m_busy && (m_cnt < 16) && m_mask[m_cnt % 16] && !(m_wp && m_ptr >= 1024);
         check(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
         check(arr_we == e_we, "R6 write enable", int'(arr_we), int'(e_we));
         if (e_we) begin
            check(int'(arr_addr) == e_addr, "R6 write address", int'(arr_addr), e_addr);
            check(int'(arr_data) == m_dat[m_cnt], "R6 write data", int'(arr_data), m_dat[m_cnt]);
         end
         check(int'(next_addr) == m_ptr, "R2 pointer", int'(next_addr), m_ptr);
         if (busy) busy_cnt++;
         if (arr_we) begin
            wr_cnt++;
            tb_mem[int'(arr_addr)] = int'(arr_data);
         end
      end
   end

   task automatic pulse_idle();
      @(negedge clk);
      xfer_start = 0; addr_load = 0; byte_vld = 0; stop_strb = 0;
   endtask

   task automatic do_start(input bit wp);
      @(negedge clk); wp_pin = wp; xfer_start = 1; pulse_idle();
   endtask
   task automatic do_addr(input int a);
      @(negedge clk); addr_in = AW'(a); addr_load = 1; pulse_idle();
   endtask
   task automatic do_byte(input int v);
      @(negedge clk); byte_in = DW'(v); byte_vld = 1; pulse_idle();
   endtask
   task automatic do_stop();
      @(negedge clk); stop_strb = 1; pulse_idle();
   endtask

   task automatic write_xfer(input int a, input int n, input int v0, input bit wp);
      busy_cnt = 0; wr_cnt = 0;
      do_start(wp);
      do_addr(a);
      for (int i = 0; i < n; i++) do_byte((v0 + i) & 8'hFF);
      do_stop();
   endtask

   task automatic settle();
      repeat (PROG + 6) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MEMN; i++) tb_mem[i] = 0;
      repeat (3) @(negedge clk);
      @(posedge clk); #(CLK_PERIOD/4);
      check(busy == 0, "R1 busy after reset", int'(busy), 0);
      check(arr_we == 0, "R1 no write in reset", int'(arr_we), 0);
      check(next_addr == 0, "R1 pointer after reset", int'(next_addr), 0);
      @(negedge clk); rst_n = 1;
      repeat (2) @(negedge clk);

      // single byte: page write of length one
      write_xfer(12'h012, 1, 8'hA5, 0); settle();
      check(tb_mem[12'h012] == 8'hA5, "R6 single byte stored", tb_mem[12'h012], 8'hA5);
      check(wr_cnt == 1, "R6 single write count", wr_cnt, 1);
      check(busy_cnt == PROG, "R5 busy length", busy_cnt, PROG);
      check(next_addr == 12'h013, "R2 pointer after byte", int'(next_addr), 12'h013);

      // full page from mid-page: wraps within page
      write_xfer(12'h125, 16, 8'h10, 0); settle();
      check(wr_cnt == 16, "R6 full page writes", wr_cnt, 16);
      check(tb_mem[12'h125] == 8'h10, "R2 first byte slot", tb_mem[12'h125], 8'h10);
      check(tb_mem[12'h120] == 8'h1B, "R2 wrapped byte slot", tb_mem[12'h120], 8'h1B);
      check(next_addr == 12'h125, "R2 pointer wrapped", int'(next_addr), 12'h125);

      // eighteen bytes: the 17th and 18th overwrite the 1st and 2nd
      write_xfer(12'h230, 18, 8'h40, 0); settle();
      check(tb_mem[12'h230] == 8'h50, "R3 slot 0 overwritten", tb_mem[12'h230], 8'h50);
      check(tb_mem[12'h231] == 8'h51, "R3 slot 1 overwritten", tb_mem[12'h231], 8'h51);
      check(tb_mem[12'h232] == 8'h42, "R3 slot 2 kept", tb_mem[12'h232], 8'h42);
      check(wr_cnt == 16, "R3 one write per slot", wr_cnt, 16);

      // address-only transfer
      write_xfer(12'h300, 0, 0, 0); settle();
      check(busy_cnt == 0, "R4 no busy without data", busy_cnt, 0);
      check(wr_cnt == 0, "R4 no write without data", wr_cnt, 0);
      check(next_addr == 12'h300, "R4 pointer loaded", int'(next_addr), 12'h300);

      // guarded upper half
      write_xfer(12'h455, 3, 8'h77, 1); settle();
      check(wr_cnt == 0, "R7 upper half blocked", wr_cnt, 0);
      check(busy_cnt == PROG, "R7 busy still runs", busy_cnt, PROG);
      check(tb_mem[12'h455] == 0, "R7 cell untouched", tb_mem[12'h455], 0);

      // guard high but lower half
      write_xfer(12'h155, 2, 8'h90, 1); settle();
      check(wr_cnt == 2, "R7 lower half allowed", wr_cnt, 2);
      check(tb_mem[12'h156] == 8'h91, "R7 lower half data", tb_mem[12'h156], 8'h91);

      // partial rewrite of an earlier page: old slots not rewritten
      write_xfer(12'h12E, 2, 8'hC0, 0); settle();
      check(wr_cnt == 2, "R9 only new slots written", wr_cnt, 2);
      check(tb_mem[12'h12F] == 8'hC1, "R9 new data", tb_mem[12'h12F], 8'hC1);
      check(tb_mem[12'h125] == 8'h10, "R9 old data kept", tb_mem[12'h125], 8'h10);

      // strobes during busy are ignored
      write_xfer(12'h040, 2, 8'h33, 0);
      do_start(0); do_addr(12'h600); do_byte(8'hEE); do_stop();
      settle();
      check(busy_cnt == PROG, "R8 no second program cycle", busy_cnt, PROG);
      check(wr_cnt == 2, "R8 no extra write", wr_cnt, 2);
      check(next_addr == 12'h042, "R8 pointer unchanged", int'(next_addr), 12'h042);
      check(tb_mem[12'h600] == 0, "R8 ignored byte not written", tb_mem[12'h600], 0);

      // top page, write-control low: upper half allowed, wrap at page end
      write_xfer(12'h7FE, 3, 8'h61, 0); settle();
      check(tb_mem[12'h7F0] == 8'h63, "R7 upper half written when low", tb_mem[12'h7F0], 8'h63);
      check(next_addr == 12'h7F1, "R2 top page wrap", int'(next_addr), 12'h7F1);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule